// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Engine

This engine moves a block of words between memory and one peripheral without the processor touching each word. While the processor holds the bus, the engine is an ordinary slave. A chip-select and a register-select strobe, plus one address bit, reach three registers: a memory pointer, a remaining-word tally and a mode word. The shared read and write strobes act as inputs in this phase.

Setting the go bit in the mode word arms the engine. When the peripheral then asks for service, the engine asks the processor for the bus. Once the bus is granted, the same read and write strobes become outputs. The engine drives the memory pointer onto the address lines and acknowledges the peripheral for each word. Two release policies exist. In burst mode the engine keeps the bus for a continuous run of words. In cycle-stealing mode it moves one word and then hands the bus back. When the tally reaches zero the engine releases the bus and raises an interrupt. The interrupt stays up until the processor writes the mode word again.

The bidirectional lines are split into separate input, output and enable pins. The peripheral side is a plain request/acknowledge pair with no data path, so there is no valid/ready stream at this boundary. A word is moved in every cycle in which the acknowledge is high, and the only back-pressure is the peripheral dropping its request.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, bus_req, drive_en, rd_out, wr_out, dev_ack and irq are low, and all three registers read back as zero.
- R2: With bus_grant low, a cycle with cpu_sel and cpu_wr high writes cpu_wdata into one register: cpu_rsel=0 selects the mode word, cpu_rsel=1 with cpu_a0=0 selects the pointer, and cpu_rsel=1 with cpu_a0=1 selects the tally. With cpu_sel and cpu_rd high, cpu_rdata shows the selected register, zero-extended; otherwise cpu_rdata is zero. Mode word bits: bit 0 go, bit 1 direction (1 = memory read toward the device, 0 = memory write from the device), bit 2 burst.
- R3: While bus_grant is high, processor reads return zero and processor writes leave the registers unchanged.
- R4: With go set and a non-zero tally, bus_req rises only after dev_req is high, and only while bus_grant is low.
- R5: In each granted transfer cycle, drive_en and dev_ack are high and mem_addr equals the pointer. rd_out is high when direction is 1, and wr_out is high when direction is 0, never both.
- R6: Each moved word raises the pointer by one, wrapping at 2^AW, and lowers the tally by one.
- R7: In burst mode with dev_req held, words move in consecutive cycles and bus_req stays high until the last word.
- R8: In cycle-stealing mode bus_req falls after every word and stays low for at least one cycle. It rises again only while dev_req is high.
- R9: When the tally reaches zero, bus_req falls, the go bit clears and irq rises.
- R10: irq stays high until the processor writes the mode word. Other writes and all reads leave it high.
- R11: Setting go with a tally of zero raises irq on the next cycle, clears go, and never asserts bus_req or drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_sel | input | 1 | Chip select from processor |
| cpu_rsel | input | 1 | Register select (0 mode word, 1 pointer/tally) |
| cpu_a0 | input | 1 | Address bit choosing pointer (0) or tally (1) |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| rd_in | input | 1 | Read strobe when processor owns the bus |
| wr_in | input | 1 | Write strobe when processor owns the bus |
| rd_out | output | 1 | Memory read strobe driven by the engine |
| wr_out | output | 1 | Memory write strobe driven by the engine |
| drive_en | output | 1 | Output enable for mem_addr, rd_out, wr_out |
| mem_addr | output | AW | Memory address while the engine owns the bus |
| bus_req | output | 1 | Bus request to processor |
| bus_grant | input | 1 | Bus grant from processor |
| dev_req | input | 1 | Service request from peripheral |
| dev_ack | output | 1 | Per-word acknowledge to peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with AW=12, CW=6 and DW=16. The narrow address lets a short transfer cross the 12-bit boundary, so the pointer wrap from 0xFFF to 0x000 is checked. The wide data word shows the zero-extension of narrow registers on read. A small tally keeps the burst and cycle-stealing runs to a handful of words. The bench's processor model grants the bus one half-cycle after each request, which exercises the one-cycle release gap between stolen words.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;

  localparam int MODE_W     = 3;
  localparam int MODE_GO    = 0;
  localparam int MODE_DIR   = 1;
  localparam int MODE_BURST = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_rsel,
  input  logic          cpu_a0,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          bus_grant,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          step,
  input  logic          done,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output logic          go,
  output logic          dir,
  output logic          burst,
  output logic          irq
);
  logic              cpu_ok;
  logic              wr_mode, wr_addr, wr_cnt;
  logic [MODE_W-1:0] mode_q;

  assign cpu_ok  = cpu_sel && !bus_grant;
  assign wr_mode = cpu_ok && cpu_wr && !cpu_rsel;
  assign wr_addr = cpu_ok && cpu_wr && cpu_rsel && !cpu_a0;
  assign wr_cnt  = cpu_ok && cpu_wr && cpu_rsel && cpu_a0;

  assign go    = mode_q[MODE_GO];
  assign dir   = mode_q[MODE_DIR];
  assign burst = mode_q[MODE_BURST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      mode_q  <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_addr)   addr_q <= cpu_wdata[AW-1:0];
      else if (step) addr_q <= addr_q + 1'b1;

      if (wr_cnt)    count_q <= cpu_wdata[CW-1:0];
      else if (step) count_q <= count_q - 1'b1;

      if (wr_mode)   mode_q <= cpu_wdata[MODE_W-1:0];
      else if (done) mode_q[MODE_GO] <= 1'b0;

      if (done)         irq <= 1'b1;
      else if (wr_mode) irq <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_ok && cpu_rd) begin
      if (!cpu_rsel)   cpu_rdata[MODE_W-1:0] = mode_q;
      else if (!cpu_a0) cpu_rdata[AW-1:0]    = addr_q;
      else              cpu_rdata[CW-1:0]    = count_q;
    end
  end

  // R6
  step_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == AW'($past(addr_q) + 1'b1)) && (count_q == CW'($past(count_q) - 1'b1)));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_mode |=> irq);

  // R3
  grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant && !step |=> $stable(addr_q) && $stable(count_q));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir,
  input  logic          burst,
  input  logic [CW-1:0] count_q,
  input  logic          bus_grant,
  input  logic          dev_req,
  output logic          bus_req,
  output logic          drive_en,
  output logic          rd_out,
  output logic          wr_out,
  output logic          dev_ack,
  output logic          step,
  output logic          done
);
  seq_state_t st, st_nx;
  logic cnt_zero, cnt_last, xfer_act, zero_start;

  assign cnt_zero   = (count_q == '0);
  assign cnt_last   = (count_q == CW'(1));
  assign xfer_act   = (st == ST_XFER) && bus_grant;
  assign zero_start = (st == ST_IDLE) && go && cnt_zero;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (go && !cnt_zero && dev_req && !bus_grant) st_nx = ST_REQ;
      ST_REQ:  if (bus_grant) st_nx = ST_XFER;
      ST_XFER: if (bus_grant) begin
                 if (cnt_last)              st_nx = ST_IDLE;
                 else if (burst && dev_req) st_nx = ST_XFER;
                 else                       st_nx = ST_IDLE;
               end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign bus_req  = (st != ST_IDLE);
  assign drive_en = xfer_act;
  assign rd_out   = xfer_act && dir;
  assign wr_out   = xfer_act && !dir;
  assign dev_ack  = xfer_act;
  assign step     = xfer_act;
  assign done     = (xfer_act && cnt_last) || zero_start;

  // R8
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_act && !burst |=> !bus_req);

  // R4
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_req) && !$past(bus_grant));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !bus_req);

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_act && burst && dev_req && !cnt_last |=> drive_en || !bus_grant);

  // R11
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> !bus_req && !drive_en);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_rsel,
  input  logic          cpu_a0,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rd_in,
  input  logic          wr_in,
  output logic          rd_out,
  output logic          wr_out,
  output logic          drive_en,
  output logic [AW-1:0] mem_addr,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic          irq
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic go, dir, burst, step, done;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_rsel(cpu_rsel), .cpu_a0(cpu_a0),
    .cpu_rd(rd_in), .cpu_wr(wr_in), .bus_grant(bus_grant),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .step(step), .done(done),
    .addr_q(addr_q), .count_q(count_q),
    .go(go), .dir(dir), .burst(burst), .irq(irq)
  );

  dma_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .dir(dir), .burst(burst), .count_q(count_q),
    .bus_grant(bus_grant), .dev_req(dev_req),
    .bus_req(bus_req), .drive_en(drive_en),
    .rd_out(rd_out), .wr_out(wr_out), .dev_ack(dev_ack),
    .step(step), .done(done)
  );

  assign mem_addr = addr_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> bus_grant && (rd_out != wr_out) && dev_ack);
endmodule

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  localparam int AW = 12;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 0, cpu_rsel = 0, cpu_a0 = 0, rd_in = 0, wr_in = 0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic rd_out, wr_out, drive_en, bus_req, dev_ack, irq;
  logic [AW-1:0] mem_addr;
  logic bus_grant = 0, dev_req = 0;
  logic auto_grant = 1;

  int checks = 0, errors = 0;
  bit mon_on = 0;
  int words, rds, wrs, noack, falls, addr_err;
  logic [AW-1:0] first_addr, last_addr;
  logic prev_req;

  always #10 clk = ~clk;

  dma_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rsel(cpu_rsel),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rd_in(rd_in), .wr_in(wr_in), .rd_out(rd_out), .wr_out(wr_out),
    .drive_en(drive_en), .mem_addr(mem_addr), .bus_req(bus_req),
    .bus_grant(bus_grant), .dev_req(dev_req), .dev_ack(dev_ack), .irq(irq)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (auto_grant) bus_grant = bus_req;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        if (drive_en) begin
          if (words == 0) first_addr = mem_addr;
          else if (mem_addr != ((last_addr + 1'b1) & AMASK)) addr_err++;
          last_addr = mem_addr;
          words++;
          if (rd_out) rds++;
          if (wr_out) wrs++;
          if (!dev_ack) noack++;
        end
        if (prev_req && !bus_req) falls++;
        prev_req = bus_req;
      end
    end
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon_reset();
    words = 0; rds = 0; wrs = 0; noack = 0; falls = 0; addr_err = 0;
    first_addr = '0; last_addr = '0; prev_req = bus_req; mon_on = 1;
  endtask

  task automatic cpu_write(input logic rs, input logic a0, input int val);
    @(negedge clk);
    cpu_sel = 1; cpu_rsel = rs; cpu_a0 = a0; cpu_wdata = DW'(val); wr_in = 1;
    @(negedge clk);
    cpu_sel = 0; wr_in = 0; cpu_wdata = '0;
  endtask

  task automatic cpu_read(input logic rs, input logic a0, output int val);
    @(negedge clk);
    cpu_sel = 1; cpu_rsel = rs; cpu_a0 = a0; rd_in = 1;
    #2;
    val = int'(cpu_rdata);
    cpu_sel = 0; rd_in = 0;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #2;
      if (irq) break;
    end
  endtask

  task automatic t_reset();
    int v;
    #2;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 drive_en", drive_en | rd_out | wr_out | dev_ack, 0);
    chk("R1 irq", irq, 0);
    cpu_read(0, 0, v); chk("R1 mode", v, 0);
    cpu_read(1, 0, v); chk("R1 pointer", v, 0);
    cpu_read(1, 1, v); chk("R1 tally", v, 0);
  endtask

  task automatic t_regs();
    int v;
    cpu_write(1, 0, 'h100);
    cpu_write(1, 1, 'h25);
    cpu_write(0, 0, 'h6);
    cpu_read(1, 0, v); chk("R2 pointer", v, 'h100);
    cpu_read(1, 1, v); chk("R2 tally", v, 'h25);
    cpu_read(0, 0, v); chk("R2 mode", v, 'h6);
    @(negedge clk);
    cpu_sel = 0; cpu_rsel = 1; rd_in = 1; #2;
    chk("R2 unselected read", int'(cpu_rdata), 0);
    rd_in = 0;
    cpu_write(1, 0, 'hF123);
    cpu_read(1, 0, v); chk("R2 pointer truncated to AW", v, 'h123);
    cpu_write(1, 0, 'h100);
  endtask

  task automatic t_grant_block();
    int v;
    auto_grant = 0;
    @(negedge clk); bus_grant = 1;
    cpu_write(1, 0, 'hABC);
    cpu_write(1, 1, 'h3);
    cpu_read(1, 0, v); chk("R3 read during grant", v, 0);
    @(negedge clk); bus_grant = 0;
    auto_grant = 1;
    cpu_read(1, 0, v); chk("R3 pointer kept", v, 'h100);
    cpu_read(1, 1, v); chk("R3 tally kept", v, 'h25);
  endtask

  task automatic t_zero_start();
    int v;
    mon_reset();
    cpu_write(1, 1, 0);
    cpu_write(0, 0, 'h1);
    @(negedge clk); #2;
    chk("R11 irq on zero tally", irq, 1);
    repeat (5) @(negedge clk);
    #2;
    chk("R11 no bus request", falls + int'(bus_req), 0);
    chk("R11 no access", words, 0);
    cpu_read(0, 0, v); chk("R11 go cleared", v, 0);
    cpu_write(1, 0, 'h55);
    #2; chk("R10 irq held after other write", irq, 1);
    cpu_write(0, 0, 0);
    #2; chk("R10 irq cleared by mode write", irq, 0);
    mon_on = 0;
  endtask

  task automatic t_burst();
    int v;
    cpu_write(1, 0, 'h200);
    cpu_write(1, 1, 4);
    mon_reset();
    cpu_write(0, 0, 'h7);
    repeat (3) @(negedge clk);
    #2; chk("R4 no request before dev_req", bus_req, 0);
    dev_req = 1;
    wait_irq(50);
    dev_req = 0;
    chk("R9 irq after burst", irq, 1);
    chk("R7 burst words", words, 4);
    chk("R7 single release", falls, 1);
    chk("R5 read strobes", rds, 4);
    chk("R5 ack per word", noack, 0);
    chk("R5 first address", first_addr, 'h200);
    chk("R6 consecutive addresses", addr_err, 0);
    #2; chk("R9 bus_req low", bus_req, 0);
    cpu_read(1, 0, v); chk("R6 pointer end", v, 'h204);
    cpu_read(1, 1, v); chk("R6 tally end", v, 0);
    cpu_read(0, 0, v); chk("R9 go cleared", v, 'h6);
    mon_on = 0;
    cpu_write(0, 0, 0);
  endtask

  task automatic t_steal();
    int v;
    cpu_write(1, 0, 'hFFE);
    cpu_write(1, 1, 3);
    mon_reset();
    cpu_write(0, 0, 'h1);
    dev_req = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      if (words >= 1) break;
    end
    dev_req = 0;
    repeat (8) @(negedge clk);
    #2;
    chk("R8 one word then hold", words, 1);
    chk("R8 no re-request without dev_req", bus_req, 0);
    dev_req = 1;
    wait_irq(60);
    dev_req = 0;
    chk("R9 irq after steal", irq, 1);
    chk("R8 steal words", words, 3);
    chk("R8 release per word", falls, 3);
    chk("R5 write strobes", wrs, 3);
    chk("R6 wrap sequence", addr_err, 0);
    cpu_read(1, 0, v); chk("R6 pointer wrapped", v, 'h001);
    mon_on = 0;
    cpu_write(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_grant_block();
    t_zero_start();
    t_burst();
    t_steal();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule